// File: doc/BRIEF.md
# Atomic read-modify-write memory unit

This block sits between requesters and a single-ported synchronous RAM and runs atomic instructions as indivisible sequences. A request carries an instruction kind, a fetch operation code, an access size, a word address and up to four operand words. The unit reads the addressed word (or an aligned pair of words), computes the new value, writes it back and returns the value it read. Between its first read and its last write it holds a lock on the RAM port, and no other access is admitted during that window.

Eight fetch-and-operate operations are supported: add, clear (AND with the inverted operand), exclusive-or, set (OR), and signed and unsigned maximum and minimum. A flag selects the store form, which updates memory but returns no data. Swap writes the supplied value and returns the old one. Compare-and-swap writes only when the read value equals the compare operand. A paired compare-and-swap compares and updates two adjacent words as one unit. A second, plain read/write port shares the RAM and is stalled while the lock is held.

Top module: `atom_rmw_unit`

## Requirements
- R1: `req_ready` is high only while the unit is idle. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high, and the unit issues a RAM read in the cycle that follows acceptance.
- R2: `mem_lock` is high from the cycle of the first RAM read through the cycle of the last RAM write of an atomic sequence. In the completion cycle (`rsp_valid` high) the lock is low.
- R3: The plain port is granted (`ext_ready` high) only when the lock is low and no atomic request is waiting in the idle state, so atomic requests win a tie. A plain write issued during an atomic sequence lands after that sequence's write. A plain read returns the RAM word with `ext_rvalid` one cycle after the grant.
- R4: Fetch codes 0 add, 1 clear (old AND NOT operand), 2 exclusive-or and 3 set (old OR operand) write the result of the operation to memory and return the old value. The add wraps within the access width.
- R5: Fetch codes 4 (signed maximum) and 5 (signed minimum) compare the lane values as two's-complement numbers at the access width.
- R6: Fetch codes 6 (unsigned maximum) and 7 (unsigned minimum) compare the lane values as unsigned numbers.
- R7: With the store-form flag set, a fetch operation still updates memory, but `rsp_data` is zero.
- R8: Swap (kind 1) writes the lane of `req_opb` and returns the old lane value.
- R9: Compare-and-swap (kind 2) writes the lane of `req_opb` only when the old lane equals the lane of `req_opa`, and leaves memory unchanged otherwise. It returns the old lane value in both cases.
- R10: Paired compare-and-swap (kind 3) uses the even base address (address bit 0 cleared) and base+1 at full width. It writes `req_opb` and `req_opb_hi` only when both old words equal `req_opa` and `req_opa_hi`. It returns both old words on `rsp_data` and `rsp_data_hi`.
- R11: Size 0 works on bits [7:0] and size 1 on bits [15:0]; sizes 2 and 3 work on the full word. Bits above the lane are preserved in memory, and returned data is zero-extended.
- R12: After reset the unit is idle: `req_ready` and `ext_ready` are high, and `rsp_valid`, `mem_lock` and `mem_en` are low.
- R13: `rsp_valid` rises in the 5th cycle after acceptance for a single-word sequence that writes and in the 4th when it does not write. For a paired sequence it rises in the 7th cycle when it writes and in the 5th when it does not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Atomic request valid |
| req_ready | output | 1 | Unit can accept a request |
| req_kind | input | 2 | 0 fetch-op, 1 swap, 2 compare-and-swap, 3 paired compare-and-swap |
| req_fop | input | 3 | Fetch operation code (see R4 to R6) |
| req_nort | input | 1 | Store form: no data returned |
| req_size | input | 2 | Lane size: 0 byte, 1 half, 2/3 word |
| req_addr | input | ADDR_W | Word address |
| req_opa | input | DATA_W | Operand or compare value (low word) |
| req_opb | input | DATA_W | Swap or new value (low word) |
| req_opa_hi | input | DATA_W | Compare value for the high word of a pair |
| req_opb_hi | input | DATA_W | New value for the high word of a pair |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | DATA_W | Old lane value, zero-extended |
| rsp_data_hi | output | DATA_W | Old high word of a pair |
| ext_valid | input | 1 | Plain access request |
| ext_ready | output | 1 | Plain access granted this cycle |
| ext_we | input | 1 | Plain access is a write |
| ext_addr | input | ADDR_W | Plain access address |
| ext_wdata | input | DATA_W | Plain write data |
| ext_rdata | output | DATA_W | Plain read data |
| ext_rvalid | output | 1 | Plain read data valid |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_rdata | input | DATA_W | RAM read data, one cycle after a read |
| mem_lock | output | 1 | RAM port locked by an atomic sequence |

## Verification
The assertions check the control skeleton on every cycle. Ready, lock and completion are mutually exclusive, the lock always opens with a read, the lock always closes into a completion, and the plain port is never granted while the lock is held. Data correctness can only be shown by the bench's scenarios. These include the value each operation writes, signed versus unsigned ordering at each lane width, preservation of upper bits, the conditional writes of single and paired compare-and-swap, the store form's empty response, and the ordering of a plain write that competes with an atomic sequence.

// File: rtl/atom_pkg.sv
package atom_pkg;

    typedef enum logic [1:0] {
        K_FETCH = 2'd0,
        K_SWAP  = 2'd1,
        K_CAS   = 2'd2,
        K_CASP  = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        F_ADD  = 3'd0,
        F_CLR  = 3'd1,
        F_EOR  = 3'd2,
        F_SET  = 3'd3,
        F_SMAX = 3'd4,
        F_SMIN = 3'd5,
        F_UMAX = 3'd6,
        F_UMIN = 3'd7
    } fop_e;

    typedef enum logic [2:0] {
        P_IDLE   = 3'd0,
        P_RD_LO  = 3'd1,
        P_GET_LO = 3'd2,
        P_GET_HI = 3'd3,
        P_EVAL   = 3'd4,
        P_WR_LO  = 3'd5,
        P_WR_HI  = 3'd6,
        P_DONE   = 3'd7
    } phase_e;

endpackage

// File: rtl/atom_alu.sv
module atom_alu
    import atom_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        kind,
    input  logic [2:0]        fop,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] old_lo,
    input  logic [DATA_W-1:0] old_hi,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [DATA_W-1:0] opa_hi,
    input  logic [DATA_W-1:0] opb_hi,
    output logic [DATA_W-1:0] wr_lo,
    output logic [DATA_W-1:0] wr_hi,
    output logic              do_write,
    output logic [DATA_W-1:0] ret_lo
);

    localparam int LANE_MIN = 8;

    function automatic logic [DATA_W-1:0] lane_mask(input logic [1:0] sz);
        logic [DATA_W-1:0] m;
        int                bits;
        bits = LANE_MIN << sz;
        m    = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < bits) m[i] = 1'b1;
        end
        return m;
    endfunction

    logic [1:0]        eff_size;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] topbit;
    logic [DATA_W-1:0] a;
    logic [DATA_W-1:0] b;
    logic [DATA_W-1:0] nv;
    logic              a_neg;
    logic              b_neg;
    logic              lt_u;
    logic              lt_s;
    logic [DATA_W-1:0] res;
    logic [DATA_W-1:0] lane_new;
    logic              match_lo;
    logic              match_hi;

    always_comb begin
        eff_size = (kind_e'(kind) == K_CASP) ? 2'd3 : size;
        mask     = lane_mask(eff_size);
        topbit   = mask & ~(mask >> 1);
        a        = old_lo & mask;
        b        = opa & mask;
        nv       = opb & mask;
        a_neg    = |(a & topbit);
        b_neg    = |(b & topbit);
        lt_u     = a < b;
        lt_s     = (a_neg != b_neg) ? a_neg : lt_u;

        case (fop_e'(fop))
            F_ADD:   res = a + b;
            F_CLR:   res = a & ~b;
            F_EOR:   res = a ^ b;
            F_SET:   res = a | b;
            F_SMAX:  res = lt_s ? b : a;
            F_SMIN:  res = lt_s ? a : b;
            F_UMAX:  res = lt_u ? b : a;
            F_UMIN:  res = lt_u ? a : b;
            default: res = a;
        endcase

        match_lo = (a == b);
        match_hi = (old_hi == opa_hi);

        case (kind_e'(kind))
            K_FETCH: begin lane_new = res; do_write = 1'b1;                 end
            K_SWAP:  begin lane_new = nv;  do_write = 1'b1;                 end
            K_CAS:   begin lane_new = nv;  do_write = match_lo;             end
            K_CASP:  begin lane_new = nv;  do_write = match_lo && match_hi; end
            default: begin lane_new = a;   do_write = 1'b0;                 end
        endcase

        wr_lo  = (old_lo & ~mask) | (lane_new & mask);
        wr_hi  = opb_hi;
        ret_lo = a;
    end

endmodule

// File: rtl/atom_arb.sv
module atom_arb #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              own_en,
    input  logic              own_we,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [DATA_W-1:0] own_wdata,
    input  logic              lock,
    input  logic              pend,
    input  logic              ext_valid,
    output logic              ext_ready,
    input  logic              ext_we,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic [DATA_W-1:0] ext_wdata,
    output logic [DATA_W-1:0] ext_rdata,
    output logic              ext_rvalid,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    logic ext_go;
    logic rv_d;
    logic rv_q;

    always_comb begin
        ext_ready = !lock && !pend && !own_en;
        ext_go    = ext_valid && ext_ready;
        if (own_en) begin
            mem_en    = 1'b1;
            mem_we    = own_we;
            mem_addr  = own_addr;
            mem_wdata = own_wdata;
        end else begin
            mem_en    = ext_go;
            mem_we    = ext_go && ext_we;
            mem_addr  = ext_addr;
            mem_wdata = ext_wdata;
        end
        rv_d      = ext_go && !ext_we;
        ext_rdata = mem_rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rv_q <= 1'b0;
        else        rv_q <= rv_d;
    end

    assign ext_rvalid = rv_q;

endmodule

// File: rtl/atom_rmw_unit.sv
module atom_rmw_unit
    import atom_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [2:0]        req_fop,
    input  logic              req_nort,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_opa,
    input  logic [DATA_W-1:0] req_opb,
    input  logic [DATA_W-1:0] req_opa_hi,
    input  logic [DATA_W-1:0] req_opb_hi,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [DATA_W-1:0] rsp_data_hi,
    input  logic              ext_valid,
    output logic              ext_ready,
    input  logic              ext_we,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic [DATA_W-1:0] ext_wdata,
    output logic [DATA_W-1:0] ext_rdata,
    output logic              ext_rvalid,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_lock
);

    localparam int HI_OFS = 1;

    typedef struct packed {
        phase_e            ph;
        kind_e             kind;
        fop_e              fop;
        logic              nort;
        logic [1:0]        size;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] opa;
        logic [DATA_W-1:0] opb;
        logic [DATA_W-1:0] opa_hi;
        logic [DATA_W-1:0] opb_hi;
        logic [DATA_W-1:0] old_lo;
        logic [DATA_W-1:0] old_hi;
        logic [DATA_W-1:0] wlo;
        logic [DATA_W-1:0] whi;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic              own_en;
    logic              own_we;
    logic [ADDR_W-1:0] own_addr;
    logic [DATA_W-1:0] own_wdata;
    logic [ADDR_W-1:0] addr_hi;
    logic              lock;
    logic              pend;
    logic [DATA_W-1:0] alu_wlo;
    logic [DATA_W-1:0] alu_whi;
    logic              alu_wr;
    logic [DATA_W-1:0] alu_ret;

    atom_alu #(.DATA_W(DATA_W)) u_alu (
        .kind     (st_q.kind),
        .fop      (st_q.fop),
        .size     (st_q.size),
        .old_lo   (st_q.old_lo),
        .old_hi   (st_q.old_hi),
        .opa      (st_q.opa),
        .opb      (st_q.opb),
        .opa_hi   (st_q.opa_hi),
        .opb_hi   (st_q.opb_hi),
        .wr_lo    (alu_wlo),
        .wr_hi    (alu_whi),
        .do_write (alu_wr),
        .ret_lo   (alu_ret)
    );

    always_comb begin
        st_d      = st_q;
        own_en    = 1'b0;
        own_we    = 1'b0;
        addr_hi   = st_q.addr + ADDR_W'(HI_OFS);
        own_addr  = st_q.addr;
        own_wdata = st_q.wlo;

        case (st_q.ph)
            P_IDLE: begin
                if (req_valid) begin
                    st_d.ph     = P_RD_LO;
                    st_d.kind   = kind_e'(req_kind);
                    st_d.fop    = fop_e'(req_fop);
                    st_d.nort   = req_nort;
                    st_d.size   = req_size;
                    st_d.opa    = req_opa;
                    st_d.opb    = req_opb;
                    st_d.opa_hi = req_opa_hi;
                    st_d.opb_hi = req_opb_hi;
                    if (kind_e'(req_kind) == K_CASP)
                        st_d.addr = {req_addr[ADDR_W-1:1], 1'b0};
                    else
                        st_d.addr = req_addr;
                end
            end
            P_RD_LO: begin
                own_en  = 1'b1;
                st_d.ph = P_GET_LO;
            end
            P_GET_LO: begin
                st_d.old_lo = mem_rdata;
                if (st_q.kind == K_CASP) begin
                    own_en   = 1'b1;
                    own_addr = addr_hi;
                    st_d.ph  = P_GET_HI;
                end else begin
                    st_d.ph  = P_EVAL;
                end
            end
            P_GET_HI: begin
                st_d.old_hi = mem_rdata;
                st_d.ph     = P_EVAL;
            end
            P_EVAL: begin
                st_d.wlo = alu_wlo;
                st_d.whi = alu_whi;
                st_d.ph  = alu_wr ? P_WR_LO : P_DONE;
            end
            P_WR_LO: begin
                own_en  = 1'b1;
                own_we  = 1'b1;
                st_d.ph = (st_q.kind == K_CASP) ? P_WR_HI : P_DONE;
            end
            P_WR_HI: begin
                own_en    = 1'b1;
                own_we    = 1'b1;
                own_addr  = addr_hi;
                own_wdata = st_q.whi;
                st_d.ph   = P_DONE;
            end
            P_DONE: begin
                st_d.ph = P_IDLE;
            end
            default: st_d.ph = P_IDLE;
        endcase

        lock      = (st_q.ph != P_IDLE) && (st_q.ph != P_DONE);
        pend      = (st_q.ph == P_IDLE) && req_valid;
        req_ready = (st_q.ph == P_IDLE);
        rsp_valid = (st_q.ph == P_DONE);

        rsp_data    = '0;
        rsp_data_hi = '0;
        if (rsp_valid) begin
            if (!(st_q.kind == K_FETCH && st_q.nort)) rsp_data = alu_ret;
            if (st_q.kind == K_CASP)                  rsp_data_hi = st_q.old_hi;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.ph <= P_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    atom_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .own_en     (own_en),
        .own_we     (own_we),
        .own_addr   (own_addr),
        .own_wdata  (own_wdata),
        .lock       (lock),
        .pend       (pend),
        .ext_valid  (ext_valid),
        .ext_ready  (ext_ready),
        .ext_we     (ext_we),
        .ext_addr   (ext_addr),
        .ext_wdata  (ext_wdata),
        .ext_rdata  (ext_rdata),
        .ext_rvalid (ext_rvalid),
        .mem_en     (mem_en),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata)
    );

    assign mem_lock = lock;

endmodule

// File: rtl/atom_rmw_unit_chk.sv
module atom_rmw_unit_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic rsp_valid,
    input logic ext_ready,
    input logic mem_en,
    input logic mem_we,
    input logic mem_lock
);

    // R1: acceptance leads straight into a locked read
    a_r1_accept_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_lock && mem_en && !mem_we));

    // R1, R2: idle, locked and completing are exclusive
    a_r2_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_ready, mem_lock, rsp_valid}));

    // R2: the lock always opens with a read
    a_r2_lock_opens_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_lock) |-> (mem_en && !mem_we));

    // R13: the lock always closes into completion
    a_r13_lock_closes_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_lock) |-> rsp_valid);

    // R3: no plain grant under lock
    a_r3_no_grant_locked: assert property (@(posedge clk) disable iff (!rst_n)
        mem_lock |-> !ext_ready);

    // R3: a waiting atomic request wins over the plain port
    a_r3_atomic_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> !ext_ready);

endmodule

bind atom_rmw_unit atom_rmw_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .ext_ready (ext_ready),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_lock  (mem_lock)
);

// File: tb/atom_rmw_unit_bench.sv
module atom_rmw_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_kind = '0;
    logic [2:0]    req_fop = '0;
    logic          req_nort = 1'b0;
    logic [1:0]    req_size = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_opa = '0, req_opb = '0, req_opa_hi = '0, req_opb_hi = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data, rsp_data_hi;
    logic          ext_valid = 1'b0;
    logic          ext_ready;
    logic          ext_we = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic [DW-1:0] ext_wdata = '0;
    logic [DW-1:0] ext_rdata;
    logic          ext_rvalid;
    logic          mem_en, mem_we, mem_lock;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;

    logic [DW-1:0] ram [1<<AW];
    logic          poke_en = 1'b0;
    logic [AW-1:0] poke_addr = '0;
    logic [DW-1:0] poke_data = '0;

    int nchk = 0;
    int nfail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (poke_en) ram[poke_addr] <= poke_data;
        else if (mem_en) begin
            if (mem_we) ram[mem_addr] <= mem_wdata;
            else        mem_rdata <= ram[mem_addr];
        end
    end

    atom_rmw_unit #(.ADDR_W(AW), .DATA_W(DW)) u_atom_rmw_unit (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_fop(req_fop), .req_nort(req_nort), .req_size(req_size),
        .req_addr(req_addr), .req_opa(req_opa), .req_opb(req_opb),
        .req_opa_hi(req_opa_hi), .req_opb_hi(req_opb_hi),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_data_hi(rsp_data_hi),
        .ext_valid(ext_valid), .ext_ready(ext_ready), .ext_we(ext_we),
        .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
        .ext_rvalid(ext_rvalid),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_lock(mem_lock)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    task automatic poke(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        poke_en = 1'b1; poke_addr = a; poke_data = d;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic run_atom(input int kind, input int fop, input bit nort, input int size,
                            input logic [AW-1:0] a, input logic [DW-1:0] oa, input logic [DW-1:0] ob,
                            input logic [DW-1:0] oah, input logic [DW-1:0] obh,
                            output logic [DW-1:0] rd, output logic [DW-1:0] rdh,
                            output int cyc, output int lk);
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'(kind); req_fop = 3'(fop); req_nort = nort;
        req_size = 2'(size); req_addr = a; req_opa = oa; req_opb = ob;
        req_opa_hi = oah; req_opb_hi = obh;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1; lk = 0;
        while (!rsp_valid && cyc < 40) begin
            if (mem_lock) lk++;
            @(negedge clk);
            cyc++;
        end
        if (mem_lock) lk++;
        rd = rsp_data; rdh = rsp_data_hi;
    endtask

    function automatic logic [DW-1:0] lmask(input int size);
        int w;
        w = (size >= 2) ? 32 : (8 << size);
        return (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    endfunction

    function automatic logic [DW-1:0] model_fetch(input int fop, input int size,
                                                  input logic [DW-1:0] mw, input logic [DW-1:0] op);
        int w;
        logic [DW-1:0] m, a, b, r;
        logic signed [DW-1:0] sa, sb;
        w  = (size >= 2) ? 32 : (8 << size);
        m  = lmask(size);
        a  = mw & m;
        b  = op & m;
        sa = $signed(a << (32 - w)) >>> (32 - w);
        sb = $signed(b << (32 - w)) >>> (32 - w);
        case (fop)
            0: r = a + b;
            1: r = a & ~b;
            2: r = a ^ b;
            3: r = a | b;
            4: r = (sa > sb) ? a : b;
            5: r = (sa < sb) ? a : b;
            6: r = (a > b) ? a : b;
            default: r = (a < b) ? a : b;
        endcase
        return (mw & ~m) | (r & m);
    endfunction

    function automatic logic [DW-1:0] pat(input int k);
        case (k)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'h1234_567F;
            3: return 32'hC3C3_0080;
            4: return 32'hFFFF_8000;
            5: return 32'h7FFF_FFFF;
            default: return 32'hA5C3_0FFF;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [DW-1:0] rd, rdh, old, expv, m;
        logic [AW-1:0] ad;
        int cyc, lk, gwait;
        logic g_lock, g_done;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 req_ready", DW'(req_ready), 1);
        chk("R12 ext_ready", DW'(ext_ready), 1);
        chk("R12 rsp_valid", DW'(rsp_valid), 0);
        chk("R12 mem_lock",  DW'(mem_lock), 0);
        chk("R12 mem_en",    DW'(mem_en), 0);

        // fetch-op sweep: R4 R5 R6 R11
        for (int f = 0; f < 8; f++) begin
            for (int s = 0; s < 4; s++) begin
                for (int i = 0; i < 7; i++) begin
                    for (int j = 0; j < 7; j++) begin
                        ad  = AW'((i * 7 + j + f) % 64);
                        old = pat(i);
                        m   = lmask(s);
                        poke(ad, old);
                        run_atom(0, f, 1'b0, s, ad, pat(j), 32'h0, 32'h0, 32'h0, rd, rdh, cyc, lk);
                        expv = model_fetch(f, s, old, pat(j));
                        if (s < 2) begin
                            chk("R11 narrow return", rd, old & m);
                            chk("R11 narrow memory", ram[ad], expv);
                        end else if (f < 4) begin
                            chk("R4 return", rd, old);
                            chk("R4 memory", ram[ad], expv);
                        end else if (f < 6) begin
                            chk("R5 return", rd, old);
                            chk("R5 memory", ram[ad], expv);
                        end else begin
                            chk("R6 return", rd, old);
                            chk("R6 memory", ram[ad], expv);
                        end
                        if (i == 0 && j == 0) begin
                            chk("R13 write latency", DW'(cyc), 5);
                            chk("R2 lock span", DW'(lk), 4);
                        end
                    end
                end
            end
        end

        // store form R7
        for (int f = 0; f < 8; f++) begin
            poke(6'd9, 32'h8000_0011);
            run_atom(0, f, 1'b1, 2, 6'd9, 32'h0000_0105, 32'h0, 32'h0, 32'h0, rd, rdh, cyc, lk);
            chk("R7 no data", rd, 32'h0);
            chk("R7 memory", ram[9], model_fetch(f, 2, 32'h8000_0011, 32'h0000_0105));
        end

        // swap R8
        for (int s = 0; s < 4; s++) begin
            poke(6'd20, 32'hDEAD_BEEF);
            run_atom(1, 0, 1'b1, s, 6'd20, 32'h0, 32'h1357_9BDF, 32'h0, 32'h0, rd, rdh, cyc, lk);
            m = lmask(s);
            chk("R8 swap return", rd, 32'hDEAD_BEEF & m);
            chk("R8 swap memory", ram[20], (32'hDEAD_BEEF & ~m) | (32'h1357_9BDF & m));
        end

        // compare-and-swap R9
        for (int s = 0; s < 4; s++) begin
            m = lmask(s);
            // matching lane; compare operand differs only above the lane
            poke(6'd30, 32'h5566_7788);
            run_atom(2, 0, 1'b0, s, 6'd30, (32'h5566_7788 & m) | (32'hFFFF_FFFF & ~m & 32'h0F0F_0000),
                     32'hAAAA_BBBB, 32'h0, 32'h0, rd, rdh, cyc, lk);
            chk("R9 hit return", rd, 32'h5566_7788 & m);
            chk("R9 hit memory", ram[30], (32'h5566_7788 & ~m) | (32'hAAAA_BBBB & m));
            chk("R13 hit latency", DW'(cyc), 5);
            // mismatching lane
            poke(6'd31, 32'h5566_7788);
            run_atom(2, 0, 1'b0, s, 6'd31, 32'h5566_7789, 32'hAAAA_BBBB, 32'h0, 32'h0, rd, rdh, cyc, lk);
            chk("R9 miss return", rd, 32'h5566_7788 & m);
            chk("R9 miss memory", ram[31], 32'h5566_7788);
            chk("R13 miss latency", DW'(cyc), 4);
            chk("R2 miss lock span", DW'(lk), 3);
        end

        // paired compare-and-swap R10, odd request address 13 -> words 12,13
        for (int c = 0; c < 4; c++) begin
            poke(6'd12, 32'h1111_0000);
            poke(6'd13, 32'h2222_0000);
            poke(6'd14, 32'h3333_0000);
            run_atom(3, 0, 1'b0, 0, 6'd13,
                     (c[0]) ? 32'h1111_0000 : 32'h1111_0001,
                     32'hCAFE_0001,
                     (c[1]) ? 32'h2222_0000 : 32'h2223_0000,
                     32'hCAFE_0002, rd, rdh, cyc, lk);
            chk("R10 old low", rd, 32'h1111_0000);
            chk("R10 old high", rdh, 32'h2222_0000);
            chk("R10 low word", ram[12], (c == 3) ? 32'hCAFE_0001 : 32'h1111_0000);
            chk("R10 high word", ram[13], (c == 3) ? 32'hCAFE_0002 : 32'h2222_0000);
            chk("R10 neighbour", ram[14], 32'h3333_0000);
            chk("R13 pair latency", DW'(cyc), (c == 3) ? 7 : 5);
        end

        // plain read R3
        poke(6'd40, 32'h0BAD_F00D);
        @(negedge clk);
        ext_valid = 1'b1; ext_we = 1'b0; ext_addr = 6'd40;
        chk("R3 idle grant", DW'(ext_ready), 1);
        @(negedge clk);
        ext_valid = 1'b0;
        chk("R3 read valid", DW'(ext_rvalid), 1);
        chk("R3 read data", ext_rdata, 32'h0BAD_F00D);

        // plain write competing with an atomic add R3
        poke(6'd5, 32'd10);
        g_lock = 1'b1; g_done = 1'b0; gwait = 0;
        fork
            run_atom(0, 0, 1'b0, 2, 6'd5, 32'd1, 32'h0, 32'h0, 32'h0, rd, rdh, cyc, lk);
            begin
                @(negedge clk);
                ext_valid = 1'b1; ext_we = 1'b1; ext_addr = 6'd5; ext_wdata = 32'd100;
                do begin
                    @(negedge clk);
                    gwait++;
                end while (!ext_ready && gwait < 40);
                g_lock = mem_lock; g_done = rsp_valid;
                @(negedge clk);
                ext_valid = 1'b0; ext_we = 1'b0;
            end
        join
        @(negedge clk);
        chk("R3 atomic saw old", rd, 32'd10);
        chk("R3 grant unlocked", DW'(g_lock), 0);
        chk("R3 grant at completion", DW'(g_done), 1);
        chk("R3 plain write last", ram[5], 32'd100);

        summary();
    end

endmodule